// File: doc/BRIEF.md
# Multicycle 16-bit Processor Core

A compact processor that runs 16-bit instructions from a single memory that holds both code and data. One ALU does all arithmetic, including advancing the program counter. Eight 16-bit general registers, an instruction register, operand latches, a memory address latch and a load data latch make up the datapath. A Moore state machine steps each instruction through fetch, decode and one or more execute states, so different instructions take different numbers of cycles.

The memory port presents an address, write data, a read strobe and a write strobe. Read data is expected in the same cycle as the address, and a write takes effect on the rising clock edge. The memory has `MEM_WORDS` words (255 by default). A store to the top word, address `MEM_WORDS-1`, also loads a display register driven on `disp_o`. The halt opcode parks the core until reset and raises `halted_o`.

Instruction fields: opcode in bits 15:13, rs in 12:10, rt in 9:7, rd in 6:4, funct in 3:0, a 7-bit immediate in 6:0 and a 13-bit jump target in 12:0. Opcodes: 0 register ops, 1 load, 2 store, 3 branch-if-equal, 4 add-immediate, 5 jump, 6 no-op, 7 halt.

Top module: `cpu16_core`

## Requirements
- R1: While rst_ni is low, the core is in fetch with PC 0: mem_rd_o=1, mem_addr_o=0, mem_we_o=0, halted_o=0, disp_o=0 and all registers zero.
- R2: Fetch drives the PC on mem_addr_o with mem_rd_o high, latches the read word into the instruction register and writes PC+1 back to the PC through the ALU, so the cycle after fetch shows address PC+1 with mem_rd_o low.
- R3: Opcode 0 writes rd with rs+rt (funct 0), rs-rt (1), rs AND rt (2), rs OR rt (3) or 1/0 for signed rs<rt (4); it takes 3 cycles.
- R4: Opcode 0 with funct 5 to 15 leaves all registers unchanged and takes 3 cycles.
- R5: Opcode 4 writes rt with rs plus the sign-extended 7-bit immediate in 3 cycles.
- R6: Opcode 1 loads rt from memory at rs+sext(imm) in 5 cycles; opcode 2 stores rt to memory at rs+sext(imm) in 4 cycles.
- R7: Opcode 3 compares rs and rt; when equal it sets PC to the incremented PC plus sext(imm) and takes 4 cycles, otherwise it takes 3 cycles.
- R8: Opcode 5 loads the PC with the zero-extended 13-bit target in 3 cycles.
- R9: Opcode 7 raises halted_o two cycles after its fetch begins; from then until reset halted_o stays high and no read or write strobe is driven.
- R10: Opcode 6 does nothing and returns to fetch after 2 cycles.
- R11: A store to address MEM_WORDS-1 loads disp_o with the stored value at the same edge; stores to any other address leave disp_o unchanged.
- R12: mem_rd_o and mem_we_o are never high together, and mem_we_o is driven only by stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 16 | Store data |
| mem_rdata_i | input | 16 | Read data, valid in the same cycle as the address |
| mem_rd_o | output | 1 | Read strobe |
| mem_we_o | output | 1 | Write strobe, applied at the rising edge |
| disp_o | output | 16 | Display register, copy of the last store to the top word |
| halted_o | output | 1 | Core is halted |

## Verification
Every register value is internal, so the bench sees results only after a program stores them. Random programs therefore keep one register as a fixed base pointing into a preloaded data area, so random loads and stores stay away from code while still chaining through arbitrary register values, and each program ends by dumping the registers before halting. Reaching the display word is hard because the immediate covers only ±64; a directed program builds the address with a chain of add-immediates, stores next to it and then to it, and branches taken and not taken around skipped code. Total cycles to halt are compared against a bench model, which pins down the per-opcode cycle counts.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

  localparam int XLEN = 16;
  localparam int REGW = 3;
  localparam int IMMW = 7;
  localparam int TGTW = 13;

  localparam logic [2:0] OP_RTYPE = 3'd0;
  localparam logic [2:0] OP_LOAD  = 3'd1;
  localparam logic [2:0] OP_STORE = 3'd2;
  localparam logic [2:0] OP_BEQ   = 3'd3;
  localparam logic [2:0] OP_ADDI  = 3'd4;
  localparam logic [2:0] OP_JUMP  = 3'd5;
  localparam logic [2:0] OP_NOP   = 3'd6;
  localparam logic [2:0] OP_HALT  = 3'd7;

  localparam logic [3:0] FN_LAST = 4'd4;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_EXEC_R, S_EXEC_I, S_ADDR, S_MEM_RD,
    S_WB, S_MEM_WR, S_BR_CMP, S_BR_TAKE, S_JUMP, S_HALT
  } state_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef enum logic [0:0] {SA_PC, SA_REG} src_a_e;
  typedef enum logic [1:0] {SB_ONE, SB_REG, SB_IMM} src_b_e;

  typedef struct packed {
    logic    mem_rd;
    logic    mem_we;
    logic    addr_mar;
    logic    ir_ld;
    logic    pc_ld;
    logic    pc_jump;
    logic    ab_ld;
    logic    mar_ld;
    logic    mdr_ld;
    logic    rf_we;
    logic    rf_dst_rd;
    logic    rf_src_mdr;
    src_a_e  src_a;
    src_b_e  src_b;
    alu_op_e alu_op;
  } ctl_t;

  function automatic alu_op_e funct_op(logic [3:0] f);
    case (f)
      4'd0:    return ALU_ADD;
      4'd1:    return ALU_SUB;
      4'd2:    return ALU_AND;
      4'd3:    return ALU_OR;
      default: return ALU_SLT;
    endcase
  endfunction

endpackage

// File: rtl/cpu16_alu.sv
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);

  always_comb begin
    case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: y_o = '0;
    endcase
  end

  assign zero_o = (y_o == '0);

endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
  parameter int W  = 16,
  parameter int N  = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rs_addr_i,
  input  logic [AW-1:0] rt_addr_i,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i,
  output logic [W-1:0]  rs_data_o,
  output logic [W-1:0]  rt_data_o
);

  logic [W-1:0] regs_q [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          regs_q[g] <= '0;
      else if (we_i && wa_i == AW'(g))      regs_q[g] <= wd_i;
    end
  end

  assign rs_data_o = regs_q[rs_addr_i];
  assign rt_data_o = regs_q[rt_addr_i];

endmodule

// File: rtl/cpu16_ctrl.sv
module cpu16_ctrl
  import cpu16_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] opcode_i,
  input  logic [3:0] funct_i,
  input  logic       zero_i,
  output state_e     state_o,
  output ctl_t       ctl_o
);

  state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_FETCH;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = S_FETCH;
    case (state_q)
      S_FETCH:  state_d = S_DECODE;
      S_DECODE: begin
        case (opcode_i)
          OP_RTYPE:          state_d = S_EXEC_R;
          OP_LOAD, OP_STORE: state_d = S_ADDR;
          OP_BEQ:            state_d = S_BR_CMP;
          OP_ADDI:           state_d = S_EXEC_I;
          OP_JUMP:           state_d = S_JUMP;
          OP_HALT:           state_d = S_HALT;
          default:           state_d = S_FETCH;
        endcase
      end
      S_ADDR:   state_d = (opcode_i == OP_LOAD) ? S_MEM_RD : S_MEM_WR;
      S_MEM_RD: state_d = S_WB;
      S_BR_CMP: state_d = zero_i ? S_BR_TAKE : S_FETCH;
      S_HALT:   state_d = S_HALT;
      default:  state_d = S_FETCH;
    endcase
  end

  // Moore outputs: a function of state and the latched instruction only
  always_comb begin
    ctl_o        = '0;
    ctl_o.src_a  = SA_REG;
    ctl_o.src_b  = SB_REG;
    ctl_o.alu_op = ALU_ADD;
    case (state_q)
      S_FETCH: begin
        ctl_o.mem_rd = 1'b1;
        ctl_o.ir_ld  = 1'b1;
        ctl_o.pc_ld  = 1'b1;
        ctl_o.src_a  = SA_PC;
        ctl_o.src_b  = SB_ONE;
      end
      S_DECODE: ctl_o.ab_ld = 1'b1;
      S_EXEC_R: begin
        ctl_o.alu_op    = funct_op(funct_i);
        ctl_o.rf_we     = (funct_i <= FN_LAST);
        ctl_o.rf_dst_rd = 1'b1;
      end
      S_EXEC_I: begin
        ctl_o.src_b = SB_IMM;
        ctl_o.rf_we = 1'b1;
      end
      S_ADDR: begin
        ctl_o.src_b  = SB_IMM;
        ctl_o.mar_ld = 1'b1;
      end
      S_MEM_RD: begin
        ctl_o.mem_rd   = 1'b1;
        ctl_o.addr_mar = 1'b1;
        ctl_o.mdr_ld   = 1'b1;
      end
      S_WB: begin
        ctl_o.rf_we      = 1'b1;
        ctl_o.rf_src_mdr = 1'b1;
      end
      S_MEM_WR: begin
        ctl_o.mem_we   = 1'b1;
        ctl_o.addr_mar = 1'b1;
      end
      S_BR_CMP: ctl_o.alu_op = ALU_SUB;
      S_BR_TAKE: begin
        ctl_o.src_a = SA_PC;
        ctl_o.src_b = SB_IMM;
        ctl_o.pc_ld = 1'b1;
      end
      S_JUMP: begin
        ctl_o.pc_ld   = 1'b1;
        ctl_o.pc_jump = 1'b1;
      end
      default: ;
    endcase
  end

  assign state_o = state_q;

  // R2
  fetch_then_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FETCH) |=> (state_q == S_DECODE));

  // R9
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HALT) |=> (state_q == S_HALT));

endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter int MEM_WORDS = 255
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            mem_rd_o,
  output logic            mem_we_o,
  output logic [XLEN-1:0] disp_o,
  output logic            halted_o
);

  localparam logic [XLEN-1:0] DISP_ADDR = XLEN'(MEM_WORDS - 1);

  state_e state;
  ctl_t   ctl;

  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, mar_q, mdr_q, disp_q;
  logic [XLEN-1:0] rs_data, rt_data, alu_a, alu_b, alu_y, imm_sx, tgt_zx, rf_wd;
  logic [REGW-1:0] rf_wa;
  logic            alu_zero;

  assign imm_sx = {{(XLEN-IMMW){ir_q[IMMW-1]}}, ir_q[IMMW-1:0]};
  assign tgt_zx = {{(XLEN-TGTW){1'b0}}, ir_q[TGTW-1:0]};

  cpu16_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (ir_q[15:13]),
    .funct_i  (ir_q[3:0]),
    .zero_i   (alu_zero),
    .state_o  (state),
    .ctl_o    (ctl)
  );

  assign rf_wa = ctl.rf_dst_rd ? ir_q[6:4] : ir_q[9:7];
  assign rf_wd = ctl.rf_src_mdr ? mdr_q : alu_y;

  cpu16_regfile #(.W(XLEN), .N(8)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rs_addr_i (ir_q[12:10]),
    .rt_addr_i (ir_q[9:7]),
    .we_i      (ctl.rf_we),
    .wa_i      (rf_wa),
    .wd_i      (rf_wd),
    .rs_data_o (rs_data),
    .rt_data_o (rt_data)
  );

  assign alu_a = (ctl.src_a == SA_PC) ? pc_q : a_q;

  always_comb begin
    case (ctl.src_b)
      SB_ONE:  alu_b = XLEN'(1);
      SB_IMM:  alu_b = imm_sx;
      default: alu_b = b_q;
    endcase
  end

  cpu16_alu #(.W(XLEN)) u_alu (
    .a_i    (alu_a),
    .b_i    (alu_b),
    .op_i   (ctl.alu_op),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      ir_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      mar_q  <= '0;
      mdr_q  <= '0;
      disp_q <= '0;
    end else begin
      if (ctl.ir_ld)  ir_q  <= mem_rdata_i;
      if (ctl.pc_ld)  pc_q  <= ctl.pc_jump ? tgt_zx : alu_y;
      if (ctl.ab_ld) begin
        a_q <= rs_data;
        b_q <= rt_data;
      end
      if (ctl.mar_ld) mar_q <= alu_y;
      if (ctl.mdr_ld) mdr_q <= mem_rdata_i;
      if (ctl.mem_we && mar_q == DISP_ADDR) disp_q <= b_q;
    end
  end

  assign mem_addr_o  = ctl.addr_mar ? mar_q : pc_q;
  assign mem_wdata_o = b_q;
  assign mem_rd_o    = ctl.mem_rd;
  assign mem_we_o    = ctl.mem_we;
  assign disp_o      = disp_q;
  assign halted_o    = (state == S_HALT);

  // R12
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_we_o));

  // R2
  pc_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_FETCH) |=> (pc_q == $past(pc_q) + XLEN'(1)));

  // R9
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && !mem_rd_o && !mem_we_o));

  // R11
  disp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_addr_o != DISP_ADDR) |=> $stable(disp_o));

  // R11
  disp_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_addr_o == DISP_ADDR) |=> (disp_o == $past(mem_wdata_o)));

endmodule

// File: tb/cpu16_core_test.sv
module cpu16_core_test;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, disp;
  logic        mem_rd, mem_we, halted;

  int checks = 0;
  int fails  = 0;
  int overlap_cnt = 0;

  logic [15:0] prog [0:254];
  logic [15:0] dmem [0:254];
  logic [15:0] rmem [0:254];
  logic [15:0] rreg [0:7];
  logic [15:0] rdisp;
  logic        load_q = 1'b0;

  always #10ns clk = ~clk;

  cpu16_core uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .mem_rd_o    (mem_rd),
    .mem_we_o    (mem_we),
    .disp_o      (disp),
    .halted_o    (halted)
  );

  always @(posedge clk) begin
    if (load_q) begin
      for (int i = 0; i < 255; i++) dmem[i] <= prog[i];
    end else if (mem_we && mem_addr < 16'd255) begin
      dmem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  assign mem_rdata = (mem_addr < 16'd255) ? dmem[mem_addr[7:0]] : 16'h0;

  always @(negedge clk) if (rst_ni && mem_rd && mem_we) overlap_cnt++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc_r(int f, int rs, int rt, int rd);
    return {3'd0, 3'(rs), 3'(rt), 3'(rd), 4'(f)};
  endfunction
  function automatic logic [15:0] enc_i(int op, int rs, int rt, int off);
    return {3'(op), 3'(rs), 3'(rt), 7'(off)};
  endfunction
  function automatic logic [15:0] enc_j(int tgt);
    return {3'd5, 13'(tgt)};
  endfunction
  localparam logic [15:0] HALT = 16'hE000;
  localparam logic [15:0] NOP  = 16'hC000;

  function automatic logic [15:0] mrd(logic [15:0] a);
    return (a < 16'd255) ? rmem[a[7:0]] : 16'h0;
  endfunction

  // Bench model of the instruction set and its cycle cost
  task automatic ref_exec(output int cyc);
    logic [15:0] pc, ir, imm, x, y, ea;
    bit done = 0;
    int steps = 0;
    for (int i = 0; i < 255; i++) rmem[i] = prog[i];
    for (int i = 0; i < 8; i++) rreg[i] = 16'h0;
    rdisp = 16'h0;
    pc = 16'h0;
    cyc = 0;
    while (!done && steps < 5000) begin
      steps++;
      ir  = mrd(pc);
      pc  = pc + 16'd1;
      imm = {{9{ir[6]}}, ir[6:0]};
      x   = rreg[ir[12:10]];
      y   = rreg[ir[9:7]];
      ea  = x + imm;
      case (ir[15:13])
        3'd0: begin
          cyc += 3;
          case (ir[3:0])
            4'd0: rreg[ir[6:4]] = x + y;
            4'd1: rreg[ir[6:4]] = x - y;
            4'd2: rreg[ir[6:4]] = x & y;
            4'd3: rreg[ir[6:4]] = x | y;
            4'd4: rreg[ir[6:4]] = ($signed(x) < $signed(y)) ? 16'd1 : 16'd0;
            default: ;
          endcase
        end
        3'd1: begin cyc += 5; rreg[ir[9:7]] = mrd(ea); end
        3'd2: begin
          cyc += 4;
          if (ea < 16'd255) rmem[ea[7:0]] = y;
          if (ea == 16'd254) rdisp = y;
        end
        3'd3: begin
          if (x == y) begin pc = pc + imm; cyc += 4; end
          else cyc += 3;
        end
        3'd4: begin cyc += 3; rreg[ir[9:7]] = ea; end
        3'd5: begin cyc += 3; pc = {3'b0, ir[12:0]}; end
        3'd6: cyc += 2;
        default: begin cyc += 2; done = 1; end
      endcase
    end
  endtask

  task automatic run_prog(input string name, output int cyc);
    int exp_cyc;
    int bad;
    rst_ni = 1'b0;
    load_q = 1'b1;
    @(negedge clk);
    @(negedge clk);
    load_q = 1'b0;
    // R1 reset state
    chk(mem_rd && !mem_we && mem_addr == 16'h0 && !halted && disp == 16'h0,
        "R1", {name, " reset outputs"},
        {mem_rd, mem_we, halted, 13'h0, disp}, 32'h8000_0000);
    ref_exec(exp_cyc);
    @(negedge clk);
    rst_ni = 1'b1;
    cyc = 0;
    while (!halted && cyc < 20000) begin
      @(posedge clk);
      #1ns;
      cyc++;
      if (cyc == 1)
        // R2 PC advanced by fetch, decode cycle does not read
        chk(mem_addr == 16'd1 && !mem_rd, "R2", {name, " addr after fetch"},
            {15'h0, mem_rd, mem_addr}, 32'h0000_0001);
    end
    // R3 R4 R5 R6 R7 R8 R10 cycle cost of the whole program
    chk(cyc == exp_cyc, "R3 R6 R7 R10", {name, " cycles to halt"}, cyc, exp_cyc);
    bad = 0;
    for (int i = 0; i < 255; i++) if (dmem[i] !== rmem[i]) begin
      if (bad == 0)
        $display("  %s first memory difference at %0d: %0h vs %0h", name, i, dmem[i], rmem[i]);
      bad++;
    end
    chk(bad == 0, "R3 R5 R6", {name, " memory image"}, bad, 0);
    chk(disp == rdisp, "R11", {name, " display"}, disp, rdisp);
  endtask

  task automatic build_random(input int n);
    int k, sel;
    for (int i = 0; i < 255; i++) prog[i] = 16'($urandom);
    k = 0;
    prog[k++] = enc_i(4, 0, 7, 60);
    prog[k++] = enc_i(4, 7, 7, 60);
    for (int s = 0; s < n; s++) begin
      sel = $urandom % 10;
      case (sel)
        0, 1, 2, 3: prog[k] = enc_r($urandom % 8, $urandom % 8, $urandom % 8, $urandom % 7);
        4, 5:       prog[k] = enc_i(4, $urandom % 8, $urandom % 7, $urandom % 128);
        6:          prog[k] = enc_i(1, 7, $urandom % 7, $urandom % 64);
        7:          prog[k] = enc_i(2, 7, $urandom % 8, $urandom % 56);
        8:          prog[k] = (s < n - 3) ? enc_i(3, $urandom % 8, $urandom % 8, $urandom % 3)
                                          : NOP;
        default:    prog[k] = {3'd6, 13'($urandom)};
      endcase
      k++;
    end
    for (int r = 0; r < 7; r++) prog[k++] = enc_i(2, 7, r, 56 + r);
    prog[k] = HALT;
  endtask

  initial begin
    #4ms;
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int cyc, hold_bad;
    void'($urandom(32'h5EED_0C0D));

    // Directed: display, signed compare, jump, branches
    for (int i = 0; i < 255; i++) prog[i] = 16'h0;
    prog[0]  = enc_i(4, 0, 1, 63);
    prog[1]  = enc_i(4, 1, 1, 63);
    prog[2]  = enc_i(4, 1, 1, 63);
    prog[3]  = enc_i(4, 1, 1, 63);
    prog[4]  = enc_i(4, 1, 1, 2);
    prog[5]  = enc_i(4, 0, 2, -5);
    prog[6]  = enc_i(2, 1, 2, -1);
    prog[7]  = enc_i(2, 1, 2, 0);
    prog[8]  = enc_r(4, 2, 0, 3);
    prog[9]  = enc_r(4, 0, 2, 4);
    prog[10] = enc_r(1, 0, 2, 5);
    prog[11] = enc_j(14);
    prog[12] = enc_i(4, 0, 6, 1);
    prog[13] = HALT;
    prog[14] = enc_i(3, 3, 4, 5);
    prog[15] = enc_i(3, 4, 0, 1);
    prog[16] = enc_i(4, 6, 6, 9);
    prog[17] = enc_i(2, 1, 3, -60);
    prog[18] = enc_i(2, 1, 4, -59);
    prog[19] = enc_i(2, 1, 5, -58);
    prog[20] = enc_i(2, 1, 6, -57);
    prog[21] = HALT;
    run_prog("directed_a", cyc);
    chk(cyc == 63, "R5 R7 R8", "directed_a exact cycles", cyc, 63);
    chk(dmem[194] == 16'd1, "R3", "slt -5<0 signed", dmem[194], 1);
    chk(dmem[195] == 16'd0, "R3", "slt 0<-5 signed", dmem[195], 0);
    chk(dmem[196] == 16'd5, "R3", "sub 0-(-5)", dmem[196], 5);
    chk(dmem[197] == 16'd0, "R7 R8", "skipped code left r6 zero", dmem[197], 0);
    chk(dmem[253] == 16'hFFFB, "R6", "store below display word", dmem[253], 16'hFFFB);
    chk(disp == 16'hFFFB, "R11", "display loaded", disp, 16'hFFFB);

    // R9: halted core stays parked with no strobes
    hold_bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(posedge clk);
      #1ns;
      if (!halted || mem_rd || mem_we) hold_bad++;
    end
    chk(hold_bad == 0, "R9", "halt holds without strobes", hold_bad, 0);

    // Directed: no-op, undefined funct, load/store timing
    for (int i = 0; i < 255; i++) prog[i] = 16'h0;
    prog[0]  = enc_i(4, 0, 1, 10);
    prog[1]  = NOP;
    prog[2]  = enc_r(9, 0, 0, 1);
    prog[3]  = enc_i(1, 1, 2, 40);
    prog[4]  = enc_i(2, 1, 2, 41);
    prog[5]  = enc_i(2, 1, 1, 42);
    prog[6]  = HALT;
    prog[50] = 16'h1234;
    run_prog("directed_b", cyc);
    chk(cyc == 23, "R10 R6", "directed_b exact cycles", cyc, 23);
    chk(dmem[51] == 16'h1234, "R6", "load then store", dmem[51], 16'h1234);
    chk(dmem[52] == 16'd10, "R4", "undefined funct kept r1", dmem[52], 10);
    chk(disp == 16'h0, "R11", "display untouched by other stores", disp, 0);

    // Random programs against the bench model
    for (int run = 0; run < 6; run++) begin
      build_random(40);
      run_prog($sformatf("random_%0d", run), cyc);
    end

    chk(overlap_cnt == 0, "R12", "read and write strobes together", overlap_cnt, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule